// File: doc/BRIEF.md
# Registered Wired-OR Bus Transceiver

This block connects a small group of bit lanes to a shared bus on which every driver can only pull a line high. A driver that outputs a low level has released the line, so the value seen on the bus is the OR of all enabled drivers. Each lane has two flops. The transmit flop either keeps its value or takes one of two local data words. The receive flop captures the bus value after it has been gated by a receive enable.

Whether the block drives the bus at all is held in an enable flop. That flop is loaded from two active-low bus-enable inputs. The bus is released only when both enables are low, and only once that condition has been clocked in. All flops run on a single effective clock, which is the OR of two clock inputs. A rising edge on either input advances the block.

The shared bus is modelled as a resolved input. The surrounding logic feeds back the OR of this block's `bus_drv` with every other driver on the bus. The block never sees a tri-state net.

Top module: `wor_bus_xcvr`

## Requirements
- R1: Synchronous active-high reset clears every transmit flop, every receive flop and the bus-enable flop. After a reset edge, `bus_drv` and `rx_q` are all zero.
- R2: When `load_a` is high at an effective clock edge, every transmit flop takes its bit of `data_a`. This holds even when `load_b` is also high.
- R3: When `load_b` is high and `load_a` is low at an effective clock edge, every transmit flop takes its bit of `data_b`.
- R4: When `load_a` and `load_b` are both low at an effective clock edge, the transmit flops keep their values.
- R5: `bus_drv` equals the transmit flops ANDed with the bus-enable flop. That flop is loaded low only when both bits of `bus_en_n` are low at an edge. A change on `bus_en_n` reaches `bus_drv` after exactly one edge, and never before it.
- R6: A lane of `bus_drv` that is low has no effect on the bus. The value captured from the bus is the OR of this block's drive and the other drivers.
- R7: When `rx_en` is high at an effective clock edge, each receive flop captures its bit of `bus_in`. The flops drive `rx_q`.
- R8: When `rx_en` is low at an effective clock edge, every receive flop captures zero.
- R9: A rising edge on `clk_b` while `clk_a` is low clocks all flops in the same way as a rising edge on `clk_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock input; rising edge advances the block |
| clk_b | input | 1 | Second clock input; ORed with clk_a to form the effective clock |
| rst | input | 1 | Synchronous active-high reset |
| data_a | input | LANES | First local transmit source |
| data_b | input | LANES | Second local transmit source |
| load_a | input | 1 | Load transmit flops from data_a (highest priority) |
| load_b | input | 1 | Load transmit flops from data_b when load_a is low |
| bus_en_n | input | 2 | Active-low bus enables; both low releases the bus after one edge |
| rx_en | input | 1 | Receive gate; low forces zero into the receive flops |
| bus_in | input | LANES | Resolved bus value (OR of all drivers) |
| bus_drv | output | LANES | This block's drive onto the bus; low means released |
| rx_q | output | LANES | Receive flop outputs |

## Verification
The assertions take two things for granted. First, `bus_in` always contains every bit of `bus_drv`, which holds because the bus is the OR of this block and others. Second, the two clock inputs never produce glitches on their OR. The bench meets the first assumption by building `bus_in` as `bus_drv` ORed with a separate word for the other drivers. It meets the second by pulsing `clk_b` only in the low half of the `clk_a` period, so each pulse gives one clean effective edge. All inputs change only on falling edges of `clk_a`, and outputs are sampled there as well.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    localparam int unsigned WBX_EN_W = 2;

    typedef enum logic [1:0] {
        TX_HOLD   = 2'd0,
        TX_LOAD_A = 2'd1,
        TX_LOAD_B = 2'd2
    } tx_sel_e;

    // Receive-side lane inputs travel together.
    typedef struct packed {
        logic gate;
        logic bus_bit;
    } rx_in_t;

    // First source wins when both load requests are present.
    function automatic tx_sel_e tx_select(input logic load_a, input logic load_b);
        if (load_a)      return TX_LOAD_A;
        else if (load_b) return TX_LOAD_B;
        else             return TX_HOLD;
    endfunction

    // Enable flop next value: released only when every active-low enable is low.
    function automatic logic oe_next(input logic [WBX_EN_W-1:0] en_n);
        return |en_n;
    endfunction

endpackage

// File: rtl/wbx_clk_merge.sv
module wbx_clk_merge (
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_eff
);
    assign clk_eff = clk_a | clk_b;
endmodule

// File: rtl/wbx_oe_reg.sv
module wbx_oe_reg
    import wbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [WBX_EN_W-1:0] en_n,
    output logic                oe
);
    always_ff @(posedge clk) begin
        if (rst) oe <= 1'b0;
        else     oe <= oe_next(en_n);
    end
endmodule

// File: rtl/wbx_tx_lane.sv
module wbx_tx_lane
    import wbx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tx_sel_e sel,
    input  logic    src_a,
    input  logic    src_b,
    input  logic    oe,
    output logic    tx_bit,
    output logic    drv_bit
);
    logic nxt;

    always_comb begin
        unique case (sel)
            TX_LOAD_A: nxt = src_a;
            TX_LOAD_B: nxt = src_b;
            default:   nxt = tx_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tx_bit <= 1'b0;
        else     tx_bit <= nxt;
    end

    // Low output is a released line.
    assign drv_bit = tx_bit & oe;
endmodule

// File: rtl/wbx_rx_lane.sv
module wbx_rx_lane
    import wbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  rx_in_t rx_in,
    output logic   q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= rx_in.bus_bit & rx_in.gate;
    end
endmodule

// File: rtl/wor_bus_xcvr.sv
module wor_bus_xcvr
    import wbx_pkg::*;
#(
    parameter int unsigned LANES = 3
) (
    input  logic                clk_a,
    input  logic                clk_b,
    input  logic                rst,
    input  logic [LANES-1:0]    data_a,
    input  logic [LANES-1:0]    data_b,
    input  logic                load_a,
    input  logic                load_b,
    input  logic [WBX_EN_W-1:0] bus_en_n,
    input  logic                rx_en,
    input  logic [LANES-1:0]    bus_in,
    output logic [LANES-1:0]    bus_drv,
    output logic [LANES-1:0]    rx_q
);
    logic             clk_eff;
    logic             oe_q;
    tx_sel_e          tx_sel;
    logic [LANES-1:0] tx_q;

    wbx_clk_merge u_clk (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .clk_eff (clk_eff)
    );

    wbx_oe_reg u_oe (
        .clk  (clk_eff),
        .rst  (rst),
        .en_n (bus_en_n),
        .oe   (oe_q)
    );

    assign tx_sel = tx_select(load_a, load_b);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rx_in_t rx_in;
        assign rx_in.gate    = rx_en;
        assign rx_in.bus_bit = bus_in[i];

        wbx_tx_lane u_tx (
            .clk     (clk_eff),
            .rst     (rst),
            .sel     (tx_sel),
            .src_a   (data_a[i]),
            .src_b   (data_b[i]),
            .oe      (oe_q),
            .tx_bit  (tx_q[i]),
            .drv_bit (bus_drv[i])
        );

        wbx_rx_lane u_rx (
            .clk   (clk_eff),
            .rst   (rst),
            .rx_in (rx_in),
            .q     (rx_q[i])
        );
    end
endmodule

// File: rtl/wbx_checker.sv
module wbx_checker #(
    parameter int unsigned LANES = 3,
    parameter int unsigned EN_W  = 2
) (
    input logic             clk_eff,
    input logic             rst,
    input logic [LANES-1:0] data_a,
    input logic [LANES-1:0] data_b,
    input logic             load_a,
    input logic             load_b,
    input logic [EN_W-1:0]  bus_en_n,
    input logic             rx_en,
    input logic [LANES-1:0] bus_in,
    input logic [LANES-1:0] bus_drv,
    input logic [LANES-1:0] rx_q,
    input logic [LANES-1:0] tx_q
);
    assert_load_a_R2: assert property (@(posedge clk_eff) disable iff (rst)
        load_a |=> tx_q == $past(data_a));

    assert_load_b_R3: assert property (@(posedge clk_eff) disable iff (rst)
        (!load_a && load_b) |=> tx_q == $past(data_b));

    assert_hold_R4: assert property (@(posedge clk_eff) disable iff (rst)
        (!load_a && !load_b) |=> $stable(tx_q));

    assert_release_R5: assert property (@(posedge clk_eff) disable iff (rst)
        (bus_en_n == '0) |=> bus_drv == '0);

    assert_drive_R5: assert property (@(posedge clk_eff) disable iff (rst)
        (bus_en_n != '0) |=> bus_drv == tx_q);

    assert_wired_or_R6: assert property (@(posedge clk_eff) disable iff (rst)
        (bus_drv & ~bus_in) == '0);

    assert_rx_cap_R7: assert property (@(posedge clk_eff) disable iff (rst)
        rx_en |=> rx_q == $past(bus_in));

    assert_rx_gate_R8: assert property (@(posedge clk_eff) disable iff (rst)
        !rx_en |=> rx_q == '0);
endmodule

bind wor_bus_xcvr wbx_checker #(.LANES(LANES), .EN_W(wbx_pkg::WBX_EN_W)) u_chk (
    .clk_eff  (clk_eff),
    .rst      (rst),
    .data_a   (data_a),
    .data_b   (data_b),
    .load_a   (load_a),
    .load_b   (load_b),
    .bus_en_n (bus_en_n),
    .rx_en    (rx_en),
    .bus_in   (bus_in),
    .bus_drv  (bus_drv),
    .rx_q     (rx_q),
    .tx_q     (tx_q)
);

// File: tb/wor_bus_xcvr_tb.sv
`timescale 1ns/100ps
module wor_bus_xcvr_tb;
    localparam int unsigned LANES = 3;

    logic             clk_a = 1'b0;
    logic             clk_b = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] data_a = '0;
    logic [LANES-1:0] data_b = '0;
    logic             load_a = 1'b0;
    logic             load_b = 1'b0;
    logic [1:0]       bus_en_n = 2'b00;
    logic             rx_en = 1'b0;
    logic [LANES-1:0] others = '0;
    logic [LANES-1:0] bus_in;
    logic [LANES-1:0] bus_drv;
    logic [LANES-1:0] rx_q;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk_a = ~clk_a;

    // Resolved bus: this block's drive ORed with the other drivers.
    assign bus_in = bus_drv | others;

    wor_bus_xcvr #(.LANES(LANES)) u_dut (
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .rst      (rst),
        .data_a   (data_a),
        .data_b   (data_b),
        .load_a   (load_a),
        .load_b   (load_b),
        .bus_en_n (bus_en_n),
        .rx_en    (rx_en),
        .bus_in   (bus_in),
        .bus_drv  (bus_drv),
        .rx_q     (rx_q)
    );

    task automatic check(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic t_reset();
        rst = 1'b1; load_a = 1'b1; data_a = 3'b111; bus_en_n = 2'b11; rx_en = 1'b1; others = 3'b101;
        tick(); tick();
        check("R1 bus_drv after reset", bus_drv, 3'b000);
        check("R1 rx_q after reset", rx_q, 3'b000);
        rst = 1'b0; load_a = 1'b0; others = 3'b000;
    endtask

    task automatic t_load_hold();
        bus_en_n = 2'b11; rx_en = 1'b1;
        load_a = 1'b1; load_b = 1'b0; data_a = 3'b101; data_b = 3'b010;
        tick(); check("R2 load from A", bus_drv, 3'b101);
        load_b = 1'b1; data_a = 3'b011; data_b = 3'b100;
        tick(); check("R2 A wins over B", bus_drv, 3'b011);
        load_a = 1'b0; data_b = 3'b110;
        tick(); check("R3 load from B", bus_drv, 3'b110);
        load_b = 1'b0; data_a = 3'b001; data_b = 3'b001;
        tick(); check("R4 hold first edge", bus_drv, 3'b110);
        tick(); check("R4 hold second edge", bus_drv, 3'b110);
    endtask

    task automatic t_oe_latency();
        bus_en_n = 2'b00;
        #0.5 check("R5 no change before edge", bus_drv, 3'b110);
        tick(); check("R5 released after edge", bus_drv, 3'b000);
        bus_en_n = 2'b01;
        #0.5 check("R5 still released before edge", bus_drv, 3'b000);
        tick(); check("R5 en bit0 high drives", bus_drv, 3'b110);
        bus_en_n = 2'b10;
        tick(); check("R5 en bit1 high drives", bus_drv, 3'b110);
    endtask

    task automatic t_wired_or();
        rx_en = 1'b1; others = 3'b001;
        tick(); check("R6 own 110 OR other 001", rx_q, 3'b111);
        others = 3'b100;
        tick(); check("R6 overlapping drivers", rx_q, 3'b110);
        bus_en_n = 2'b00; others = 3'b101;
        tick(); tick(); check("R6 released lanes do not pull", rx_q, 3'b101);
        bus_en_n = 2'b11; others = 3'b000;
        tick();
    endtask

    task automatic t_rx_gate();
        others = 3'b111; rx_en = 1'b0;
        tick(); check("R8 gate low captures zero", rx_q, 3'b000);
        rx_en = 1'b1;
        tick(); check("R7 gate high captures bus", rx_q, 3'b111);
        others = 3'b000;
        tick(); check("R7 capture own drive", rx_q, 3'b110);
    endtask

    task automatic t_clk_b();
        load_a = 1'b1; data_a = 3'b010; others = 3'b000; rx_en = 1'b1; bus_en_n = 2'b11;
        #0.5 clk_b = 1'b1;
        #0.5 clk_b = 1'b0;
        #0.3 check("R9 clk_b edge loads transmit", bus_drv, 3'b010);
        load_a = 1'b0;
        #0.1 clk_b = 1'b1;
        #0.3 clk_b = 1'b0;
        #0.2 check("R9 clk_b edge captures receive", rx_q, 3'b010);
        tick();
        check("R9 hold after clk_a edge", bus_drv, 3'b010);
    endtask

    initial begin
        @(negedge clk_a);
        t_reset();
        t_load_hold();
        t_oe_latency();
        t_wired_or();
        t_rx_gate();
        t_clk_b();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule